// File: doc/BRIEF.md
# Programmable March Memory Self-Test Controller

This block runs a march test on a single-port synchronous RAM attached to its memory port. A march test is a chain of elements. Each element walks the whole address space, either upward or downward, and performs up to two operations at every address. Each operation is a write of a data background or a read that expects that background. The elements come from a small built-in table, and an input picks which algorithm runs: a short stuck-at test or a longer test that also covers coupling faults.

A start pulse launches the test. The controller drives address, write data, enable and write-enable. It checks each read on the cycle after it is issued, which matches the one-cycle read latency of the RAM. A mismatch sets a sticky fail flag and captures the physical address of the first failure. That address is split into a row index and a column index, which name a repair candidate for a spare row or column. The test always runs to its last element.

Logical addresses can pass through a Gray-code scrambler before they reach the RAM. This changes the physical order in which cells are visited.

Top module: `march_bist`

## Requirements
- R1: After reset, `done`, `fail`, `memEn` and `memWe` are low, and `failAddr` is zero.
- R2: With `algSel`=0, the controller runs three elements: up(w0), up(r0,w1), down(r1,w0). That is 5 operations per address, one per cycle. `done` goes high on the clock edge DEPTH*5+1 edges after the edge that samples `start`. The RAM is left all zero.
- R3: With `algSel`=1, the controller runs six elements: up(w0), up(r0,w1), up(r1,w0), down(r0,w1), down(r1,w0), up(r0). That is 10 operations per address, and `done` rises DEPTH*10+1 edges after the start edge.
- R4: Each read is compared, on the cycle after it is issued, against all-zeros (data bit 0) or all-ones (data bit 1). A mismatch sets `fail`. `fail` then stays high until the next accepted start.
- R5: Only the first mismatch in traversal order is captured in `failAddr`. Ascending elements visit lower logical addresses first, and descending elements visit higher ones first.
- R6: With SCRAMBLE=1, the physical address on `memAddr` is the logical address XOR the logical address shifted right by one. `failAddr` reports the physical address.
- R7: `failRow` equals `failAddr` bits [ADDR_W-1:COL_W], and `failCol` equals bits [COL_W-1:0].
- R8: Take an up-transition coupling fault in which the aggressor has the higher logical address. The long algorithm reports the victim. The short algorithm does not fail.
- R9: A `start` pulse while a test is running has no effect on the sequence or on its length.
- R10: An accepted start clears `fail` and `failAddr` on that clock edge.
- R11: `memWe` is only high together with `memEn`, and the write data is always all-zeros or all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a test when idle or done |
| algSel | input | 1 | 0 = short stuck-at test, 1 = long coupling test |
| memEn | output | 1 | RAM access enable |
| memWe | output | 1 | RAM write enable |
| memAddr | output | ADDR_W | Physical RAM address |
| memWdata | output | DATA_W | RAM write data |
| memRdata | input | DATA_W | RAM read data, valid one cycle after a read |
| done | output | 1 | Test complete; held until the next start |
| fail | output | 1 | Sticky mismatch flag |
| failAddr | output | ADDR_W | Physical address of the first mismatch |
| failRow | output | ADDR_W-COL_W | Row index of the first mismatch |
| failCol | output | COL_W | Column index of the first mismatch |

## Verification
Both algorithms are first run on a fault-free RAM. These runs pin down the operation count and show that no false fail is raised.

Two stuck-at-0 cells and two stuck-at-1 cells are placed at the same pair of addresses. The reported address is then the higher or the lower one, which separates descending traversal from ascending traversal. Because the expected address follows the scrambled order, the same runs also check the scrambler.

An up-transition coupling fault with its aggressor above the victim is missed by the short test and caught by the long one, which separates the two element tables. Single faults at the first and last physical cells check the row and column split. Directed runs cover a start pulse in the middle of a run and the clearing of a previous failure.

// File: rtl/march_pkg.sv
package march_pkg;

  typedef struct packed {
    logic isWrite;
    logic dataBit;
  } op_t;

  typedef struct packed {
    logic       descend;
    logic [1:0] opCount;
    op_t        op1;
    op_t        op0;
  } elem_t;

  typedef struct packed {
    logic clearLog;
    logic issue;
    logic isWrite;
    logic expBit;
  } strobe_t;

  localparam int ELEM_IDX_W = 3;

  function automatic elem_t mkElem(input logic desc, input logic [1:0] cnt,
                                   input logic w0, input logic d0,
                                   input logic w1, input logic d1);
    elem_t e;
    e.descend     = desc;
    e.opCount     = cnt;
    e.op0.isWrite = w0;
    e.op0.dataBit = d0;
    e.op1.isWrite = w1;
    e.op1.dataBit = d1;
    return e;
  endfunction

  function automatic logic [ELEM_IDX_W-1:0] algLen(input logic alg);
    return alg ? ELEM_IDX_W'(6) : ELEM_IDX_W'(3);
  endfunction

  function automatic elem_t algElem(input logic alg, input logic [ELEM_IDX_W-1:0] idx);
    elem_t e;
    e = mkElem(1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    if (!alg) begin
      case (idx)
        3'd1:    e = mkElem(1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1);
        3'd2:    e = mkElem(1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
        default: e = mkElem(1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
      endcase
    end else begin
      case (idx)
        3'd1:    e = mkElem(1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1);
        3'd2:    e = mkElem(1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
        3'd3:    e = mkElem(1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1);
        3'd4:    e = mkElem(1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
        3'd5:    e = mkElem(1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        default: e = mkElem(1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
      endcase
    end
    return e;
  endfunction

endpackage

// File: rtl/march_scramble.sv
module march_scramble #(
  parameter int ADDR_W   = 4,
  parameter bit SCRAMBLE = 1'b1
) (
  input  logic [ADDR_W-1:0] logicAddr,
  output logic [ADDR_W-1:0] physAddr
);
  generate
    if (SCRAMBLE) begin : g_gray
      assign physAddr = logicAddr ^ (logicAddr >> 1);
    end else begin : g_direct
      assign physAddr = logicAddr;
    end
  endgenerate
endmodule

// File: rtl/march_ctrl.sv
module march_ctrl
  import march_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              algSel,
  output strobe_t           strobe,
  output logic [ADDR_W-1:0] logicAddr,
  output logic              done
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_DONE} state_t;

  state_t                state;
  logic                  algReg;
  logic [ELEM_IDX_W-1:0] elemIdx;
  logic                  opIdx;
  logic [ADDR_W-1:0]     addrCnt;

  elem_t curElem;
  elem_t nextElem;
  elem_t firstElem;
  op_t   curOp;
  logic  lastOp;
  logic  lastAddr;
  logic  lastElem;
  logic  startAccept;

  always_comb begin
    curElem     = algElem(algReg, elemIdx);
    nextElem    = algElem(algReg, elemIdx + ELEM_IDX_W'(1));
    firstElem   = algElem(algSel, '0);
    curOp       = opIdx ? curElem.op1 : curElem.op0;
    lastOp      = ({1'b0, opIdx} == (curElem.opCount - 2'd1));
    lastAddr    = curElem.descend ? (addrCnt == '0) : (addrCnt == '1);
    lastElem    = (elemIdx == algLen(algReg) - ELEM_IDX_W'(1));
    startAccept = start && (state == S_IDLE || state == S_DONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      algReg  <= 1'b0;
      elemIdx <= '0;
      opIdx   <= 1'b0;
      addrCnt <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: begin
          if (startAccept) begin
            state   <= S_RUN;
            algReg  <= algSel;
            elemIdx <= '0;
            opIdx   <= 1'b0;
            addrCnt <= firstElem.descend ? '1 : '0;
          end
        end
        S_RUN: begin
          if (!lastOp) begin
            opIdx <= 1'b1;
          end else begin
            opIdx <= 1'b0;
            if (lastAddr) begin
              if (lastElem) begin
                state <= S_DRAIN;
              end else begin
                elemIdx <= elemIdx + ELEM_IDX_W'(1);
                addrCnt <= nextElem.descend ? '1 : '0;
              end
            end else if (curElem.descend) begin
              addrCnt <= addrCnt - ADDR_W'(1);
            end else begin
              addrCnt <= addrCnt + ADDR_W'(1);
            end
          end
        end
        default: state <= S_DONE;
      endcase
    end
  end

  always_comb begin
    strobe.clearLog = startAccept;
    strobe.issue    = (state == S_RUN);
    strobe.isWrite  = curOp.isWrite;
    strobe.expBit   = curOp.dataBit;
  end

  assign logicAddr = addrCnt;
  assign done      = (state == S_DONE);

  // R9: a start pulse in mid-run does not leave the run state
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && start && !(lastOp && lastAddr && lastElem)) |=> (state == S_RUN));

  // R2 / R3: element index stays inside the selected table
  a_r3_elem_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN) |-> (elemIdx < algLen(algReg)));
endmodule

// File: rtl/march_datapath.sv
module march_datapath
  import march_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int COL_W    = 2,
  parameter bit SCRAMBLE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic [ADDR_W-1:0]       logicAddr,
  input  logic [DATA_W-1:0]       memRdata,
  output logic                    memEn,
  output logic                    memWe,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [DATA_W-1:0]       memWdata,
  output logic                    fail,
  output logic [ADDR_W-1:0]       failAddr,
  output logic [ADDR_W-COL_W-1:0] failRow,
  output logic [COL_W-1:0]        failCol
);
  logic [ADDR_W-1:0] physAddr;
  logic              chkValid;
  logic              chkExp;
  logic [ADDR_W-1:0] chkAddr;
  logic              mismatch;

  march_scramble #(.ADDR_W(ADDR_W), .SCRAMBLE(SCRAMBLE)) i_scramble (
    .logicAddr(logicAddr),
    .physAddr (physAddr)
  );

  assign memEn    = strobe.issue;
  assign memWe    = strobe.issue && strobe.isWrite;
  assign memAddr  = physAddr;
  assign memWdata = {DATA_W{strobe.expBit}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkValid <= 1'b0;
      chkExp   <= 1'b0;
      chkAddr  <= '0;
    end else begin
      chkValid <= strobe.issue && !strobe.isWrite && !strobe.clearLog;
      chkExp   <= strobe.expBit;
      chkAddr  <= physAddr;
    end
  end

  assign mismatch = chkValid && (memRdata != {DATA_W{chkExp}});

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearLog) begin
      fail     <= 1'b0;
      failAddr <= '0;
    end else if (mismatch && !fail) begin
      fail     <= 1'b1;
      failAddr <= chkAddr;
    end
  end

  assign failRow = failAddr[ADDR_W-1:COL_W];
  assign failCol = failAddr[COL_W-1:0];

  // R4: the fail flag is sticky until a start clears it
  a_r4_sticky_fail: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !strobe.clearLog) |=> fail);

  // R5: the first failing address is never overwritten
  a_r5_first_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !strobe.clearLog) |=> $stable(failAddr));

  // R10: an accepted start clears the log
  a_r10_clear_log: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearLog |=> (!fail && failAddr == '0));
endmodule

// File: rtl/march_bist.sv
module march_bist
  import march_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int COL_W    = 2,
  parameter bit SCRAMBLE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    algSel,
  output logic                    memEn,
  output logic                    memWe,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [DATA_W-1:0]       memWdata,
  input  logic [DATA_W-1:0]       memRdata,
  output logic                    done,
  output logic                    fail,
  output logic [ADDR_W-1:0]       failAddr,
  output logic [ADDR_W-COL_W-1:0] failRow,
  output logic [COL_W-1:0]        failCol
);
  strobe_t           strobe;
  logic [ADDR_W-1:0] logicAddr;

  march_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .algSel   (algSel),
    .strobe   (strobe),
    .logicAddr(logicAddr),
    .done     (done)
  );

  march_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W), .SCRAMBLE(SCRAMBLE)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .logicAddr(logicAddr),
    .memRdata (memRdata),
    .memEn    (memEn),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .fail     (fail),
    .failAddr (failAddr),
    .failRow  (failRow),
    .failCol  (failCol)
  );

  // R1: a finished controller leaves the memory idle
  a_r1_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memEn);

  // R11: writes only happen with the memory enabled
  a_r11_we_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memEn);
endmodule

// File: tb/test_march_bist.sv
module test_march_bist;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int COL_W  = 2;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SHORT_CYC = DEPTH * 5 + 1;
  localparam int LONG_CYC  = DEPTH * 10 + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic algSel = 1'b0;
  logic memEn, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic [DATA_W-1:0] memRdata;
  logic done, fail;
  logic [ADDR_W-1:0] failAddr;
  logic [ADDR_W-COL_W-1:0] failRow;
  logic [COL_W-1:0] failCol;

  int checks = 0;
  int errors = 0;
  int badWrites = 0;

  always #5 clk = ~clk;

  march_bist #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W), .SCRAMBLE(1'b1)) i_march_bist (
    .clk(clk), .rstN(rstN), .start(start), .algSel(algSel),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .done(done), .fail(fail), .failAddr(failAddr),
    .failRow(failRow), .failCol(failCol)
  );

  // RAM model with fault injection
  logic [DATA_W-1:0] mem [0:DEPTH-1];
  logic saEn [0:DEPTH-1];
  logic saVal = 1'b0;
  logic cfEn = 1'b0;
  logic [ADDR_W-1:0] cfAggr = '0;
  logic [ADDR_W-1:0] cfVict = '0;
  logic clrReq = 1'b0;
  logic [DATA_W-1:0] rd;

  always @(posedge clk) begin
    if (clrReq) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      memRdata <= '0;
    end else if (memEn) begin
      if (memWe) begin
        mem[memAddr] <= memWdata;
        if (cfEn && memAddr == cfAggr && memWdata[0] && !mem[memAddr][0])
          mem[cfVict] <= '1;
      end else begin
        rd = mem[memAddr];
        if (saEn[memAddr]) rd[3] = saVal;
        memRdata <= rd;
      end
    end
  end

  // R11 monitor, sampled between edges
  always @(negedge clk) begin
    if (rstN && memWe && (!memEn || !(memWdata == '0 || memWdata == '1)))
      badWrites++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int gray(input int v);
    return v ^ (v >> 1);
  endfunction

  task automatic clearFaults();
    for (int i = 0; i < DEPTH; i++) saEn[i] = 1'b0;
    cfEn = 1'b0;
    @(negedge clk) clrReq = 1'b1;
    @(negedge clk) clrReq = 1'b0;
  endtask

  // pulse start, return number of edges until done is seen
  task automatic runTest(input logic alg, input int midStartAt, output int cyc);
    @(negedge clk);
    algSel = alg;
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    cyc = 0;
    while (1) begin
      @(posedge clk);
      cyc++;
      #1;
      if (cyc == midStartAt) begin
        start = 1'b1;
        algSel = ~alg;
        @(posedge clk);
        cyc++;
        #1 start = 1'b0;
        algSel = alg;
      end
      if (done) break;
      if (cyc > 4000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected done", cyc);
        break;
      end
    end
  endtask

  typedef struct packed {
    logic             alg;
    logic [1:0]       mode;   // 0 none, 1 stuck-0 pair, 2 stuck-1 pair, 3 coupling
    logic [ADDR_W-1:0] a;
    logic [ADDR_W-1:0] b;
    logic             expFail;
    logic [ADDR_W-1:0] expAddr;
  } vec_t;

  // Physical 5 is logical 6, physical 9 is logical 14,
  // physical 12 is logical 8, physical 3 is logical 2.
  localparam int NV = 10;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 2'd0, 4'd0,  4'd0, 1'b0, 4'd0},   // R2 clean short
    '{1'b1, 2'd0, 4'd0,  4'd0, 1'b0, 4'd0},   // R3 clean long
    '{1'b0, 2'd1, 4'd5,  4'd9, 1'b1, 4'd9},   // R5 descending r1 sees logical 14 first
    '{1'b0, 2'd2, 4'd5,  4'd9, 1'b1, 4'd5},   // R5 ascending r0 sees logical 6 first
    '{1'b1, 2'd1, 4'd5,  4'd9, 1'b1, 4'd5},   // R5 long, ascending r1
    '{1'b1, 2'd2, 4'd5,  4'd9, 1'b1, 4'd5},   // R5 long, ascending r0
    '{1'b0, 2'd3, 4'd12, 4'd3, 1'b0, 4'd0},   // R8 short misses coupling
    '{1'b1, 2'd3, 4'd12, 4'd3, 1'b1, 4'd3},   // R8 long reports victim
    '{1'b0, 2'd2, 4'd15, 4'd15, 1'b1, 4'd15}, // R7 last cell
    '{1'b1, 2'd1, 4'd0,  4'd0, 1'b1, 4'd0}    // R7 first cell
  };

  initial begin
    int cyc;
    int firstAddrs [0:3];
    vec_t v;
    for (int i = 0; i < DEPTH; i++) saEn[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 done", done, 0);
    chk("R1 fail", fail, 0);
    chk("R1 memEn", memEn, 0);
    chk("R1 memWe", memWe, 0);
    chk("R1 failAddr", failAddr, 0);
    @(negedge clk) rstN = 1'b1;

    for (int n = 0; n < NV; n++) begin
      v = VECS[n];
      clearFaults();
      if (v.mode == 2'd1 || v.mode == 2'd2) begin
        saVal = (v.mode == 2'd2);
        saEn[v.a] = 1'b1;
        saEn[v.b] = 1'b1;
      end else if (v.mode == 2'd3) begin
        cfEn = 1'b1;
        cfAggr = v.a;
        cfVict = v.b;
      end
      runTest(v.alg, -1, cyc);
      chk(v.alg ? "R3 cycles" : "R2 cycles", cyc, v.alg ? LONG_CYC : SHORT_CYC);
      chk("R4 fail", fail, v.expFail);
      chk("R5 failAddr", failAddr, v.expAddr);
      chk("R7 failRow", failRow, v.expAddr >> COL_W);
      chk("R7 failCol", failCol, v.expAddr & ((1 << COL_W) - 1));
      if (n < 2) begin
        for (int i = 0; i < DEPTH; i++) chk("R2 memory zero", mem[i], 0);
      end
    end

    // R4: fail stays high after done for many cycles
    repeat (20) @(posedge clk);
    #1 chk("R4 sticky", fail, 1);

    // R6: scramble order of the first element
    clearFaults();
    @(negedge clk);
    algSel = 1'b0;
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    // R10: previous failure cleared by the accepted start
    chk("R10 fail cleared", fail, 0);
    chk("R10 failAddr cleared", failAddr, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      firstAddrs[i] = memAddr;
      @(posedge clk);
    end
    for (int i = 0; i < 4; i++) chk("R6 scrambled address", firstAddrs[i], gray(i));
    while (!done) @(posedge clk);

    // R9: mid-run start is ignored
    clearFaults();
    runTest(1'b0, 30, cyc);
    chk("R9 cycles unchanged", cyc, SHORT_CYC);
    chk("R9 no fail", fail, 0);

    chk("R11 write data", badWrites, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule